// File: doc/BRIEF.md
# Serial PHY Lane Bring-Up Sequencer

This block takes one serial PHY lane, running in SATA mode, from reset to ready with no software in the loop. A single start pulse launches a fixed program of byte-wide register transfers on an 8-bit-address, 8-bit-data port. The program holds every reset, sets up the lane's speed, and waits for the high-frequency clocking to report not-ready. It then calibrates the termination and slew compensation and loads the values banked for the chosen link generation. After that it lets the PLL settle, programs spread-spectrum clocking, waits for the lane to report ready, and finally releases the deserializer with bit-lock detection enabled.

The generation select (1, 2 or 3) and the transmit-polarity flag are captured when start is seen. They decide which writes are made and which values those writes carry. Each of the three status waits is bounded, and a wait that runs out ends the program with an error. The done or error result stays on the outputs until the next start. Parameters give every interval in clock cycles, so a bench can shrink the millisecond-scale intervals to a few cycles.

Top module: `lane_bringup_seq`

## Requirements
- R1: After reset, reg_req, busy, done and err are all 0.
- R2: At most one transfer is outstanding. reg_req stays high with reg_addr, reg_we and reg_wdata unchanged until the cycle in which reg_ack is sampled high, and drops in the following cycle. Read data is taken from reg_rdata in the ack cycle.
- R3: The program opens with these writes, in order:
  - 0x96 to address 0x00;
  - 0x20 to 0x02, only when tx_inv was set at start;
  - 0x01 to 0x10;
  - 0x40 to 0x72;
  - a speed code to 0x12, holding (generation − 1) in bits [1:0] and again in bits [4:3].
  A gen_sel of 0 is run as generation 1.
- R4: The program then reads 0x01 until bits 0 and 1 both read 0. Each failing read is followed by at least POLL_GAP_CYC idle cycles before the next request. After POLL_LIMIT_CYC/POLL_GAP_CYC failing reads, err is raised.
- R5: Compensation setup:
  - write 0x1E to 0x41 for generation 1, or 0x0F for the others;
  - except for generation 3, write 0x33 to 0x42, then 0x02 to 0x51, then 0x2A to 0x47;
  - write 0x13 to 0x40;
  - read 0x40 back-to-back until bits 2 and 3 are both 1. If that has not happened COMP_LIMIT_CYC cycles after the first read, err is raised.
- R6: Generation-banked writes (address:value):
  - generation 3: 0x20:0x12, 0x21:0x64, 0x22:0x02, 0x23:0x00, 0x25:0x31;
  - generation 2: 0x20:0x01, 0x21:0x04, 0x22:0x02, 0x25:0x11;
  - generation 1: 0x20:0x10, 0x21:0x03, 0x22:0x04.
- R7: Next, 0x10 is written to 0x00, followed by at least SETTLE_CYC idle cycles before the next request.
- R8: Spread-spectrum setup writes 0x03 to 0x56, 0x63 to 0x57, 0x00 to 0x58 and 0xF1 to 0x59. It then writes 0x50 with 0x8D for generation 1, or 0xCD otherwise.
- R9: The program then reads 0x01 until bits 0 and 1 both read 1, with the same spacing and the same failing-read limit as R4.
- R10: The program closes with these writes, in order:
  - 0x00 to 0x10;
  - 0x00 to 0x72;
  - 0x10 to 0x00;
  - 0x08 to 0x02 (0x28 when tx_inv was set);
  - 0x61 to 0x86;
  - 0x00 to 0x00.
  Then done rises.
- R11: done and err are never high together. Each is held, with busy low, until the next start. A start pulse while busy is ignored, and gen_sel and tx_inv changes after start have no effect on the run.
- R12: Once err is raised, no further transfer is requested until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that launches the program when not busy |
| gen_sel | input | 2 | Link generation 1..3; 0 is run as 1 |
| tx_inv | input | 1 | Request transmit polarity inversion |
| reg_req | output | 1 | Transfer request, held until ack |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | Transfer complete; read data valid |
| reg_rdata | input | 8 | Read data |
| busy | output | 1 | Program running |
| done | output | 1 | Program finished successfully (held) |
| err | output | 1 | A wait timed out (held) |

## Verification
The bench runs a complete program for every generation, with and without polarity inversion, and also runs gen_sel 0. If the design skipped or misplaced a banked write, or built the speed code wrong, its transfer stream would stop matching the expected list at that entry. The bench stalls each of the three waits in turn. A design that miscounted failing reads would issue one read too many or too few before err, and one that kept running after a timeout would produce a request against an empty expected list. Other runs check the idle gaps after failing status reads and after the receiver-only reset write, so a sequencer that polls too fast or skips the settle time is flagged. A mid-run start carrying a different generation shows whether the captured configuration can be disturbed.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;

   localparam int STEP_W = 5;

   typedef enum logic [2:0] {
      OP_WR       = 3'd0,
      OP_SKIP     = 3'd1,
      OP_POLL_LO  = 3'd2,
      OP_POLL_HI  = 3'd3,
      OP_POLL_CAL = 3'd4,
      OP_SETTLE   = 3'd5,
      OP_END      = 3'd6
   } op_e;

   // val holds write data for OP_WR, the bit mask for the polls
   typedef struct packed {
      op_e        op;
      logic [7:0] addr;
      logic [7:0] val;
   } step_t;

endpackage

// File: rtl/lane_seq_timer.sv
module lane_seq_timer #(
   parameter int MAX_CNT = 16,
   parameter int CNT_W   = $clog2(MAX_CNT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0) && !load;

endmodule

// File: rtl/lane_seq_rom.sv
module lane_seq_rom
   import lane_seq_pkg::*;
(
   input  logic [STEP_W-1:0] idx,
   input  logic [1:0]        gen,   // already normalised to 1..3
   input  logic              inv,
   output step_t             step
);

   function automatic step_t wr(input logic [7:0] a, input logic [7:0] d);
      step_t s;
      s.op = OP_WR; s.addr = a; s.val = d;
      return s;
   endfunction

   function automatic step_t mk(input op_e o, input logic [7:0] a, input logic [7:0] m);
      step_t s;
      s.op = o; s.addr = a; s.val = m;
      return s;
   endfunction

   logic       g1, g3;
   logic [1:0] gm1;
   logic [7:0] spd;

   always_comb begin
      g1   = (gen == 2'd1);
      g3   = (gen == 2'd3);
      gm1  = gen - 2'd1;
      spd  = {3'b000, gm1, 1'b0, gm1};
      step = mk(OP_SKIP, 8'h00, 8'h00);
      case (idx)
         5'd0:  step = wr(8'h00, 8'h96);
         5'd1:  if (inv) step = wr(8'h02, 8'h20);
         5'd2:  step = wr(8'h10, 8'h01);
         5'd3:  step = wr(8'h72, 8'h40);
         5'd4:  step = wr(8'h12, spd);
         5'd5:  step = mk(OP_POLL_LO, 8'h01, 8'h03);
         5'd6:  step = wr(8'h41, g1 ? 8'h1E : 8'h0F);
         5'd7:  if (!g3) step = wr(8'h42, 8'h33);
         5'd8:  if (!g3) step = wr(8'h51, 8'h02);
         5'd9:  if (!g3) step = wr(8'h47, 8'h2A);
         5'd10: step = wr(8'h40, 8'h13);
         5'd11: step = mk(OP_POLL_CAL, 8'h40, 8'h0C);
         5'd12: step = wr(8'h20, g3 ? 8'h12 : (g1 ? 8'h10 : 8'h01));
         5'd13: step = wr(8'h21, g3 ? 8'h64 : (g1 ? 8'h03 : 8'h04));
         5'd14: step = wr(8'h22, g1 ? 8'h04 : 8'h02);
         5'd15: if (g3) step = wr(8'h23, 8'h00);
         5'd16: if (!g1) step = wr(8'h25, g3 ? 8'h31 : 8'h11);
         5'd17: step = wr(8'h00, 8'h10);
         5'd18: step = mk(OP_SETTLE, 8'h00, 8'h00);
         5'd19: step = wr(8'h56, 8'h03);
         5'd20: step = wr(8'h57, 8'h63);
         5'd21: step = wr(8'h58, 8'h00);
         5'd22: step = wr(8'h59, 8'hF1);
         5'd23: step = wr(8'h50, g1 ? 8'h8D : 8'hCD);
         5'd24: step = mk(OP_POLL_HI, 8'h01, 8'h03);
         5'd25: step = wr(8'h10, 8'h00);
         5'd26: step = wr(8'h72, 8'h00);
         5'd27: step = wr(8'h00, 8'h10);
         5'd28: step = wr(8'h02, inv ? 8'h28 : 8'h08);
         5'd29: step = wr(8'h86, 8'h61);
         5'd30: step = wr(8'h00, 8'h00);
         default: step = mk(OP_END, 8'h00, 8'h00);
      endcase
   end

endmodule

// File: rtl/lane_bringup_seq.sv
module lane_bringup_seq
   import lane_seq_pkg::*;
#(
   parameter int POLL_GAP_CYC   = 250_000,
   parameter int POLL_LIMIT_CYC = 12_500_000,
   parameter int SETTLE_CYC     = 12_500,
   parameter int COMP_LIMIT_CYC = 1_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] gen_sel,
   input  logic       tx_inv,
   output logic       reg_req,
   output logic       reg_we,
   output logic [7:0] reg_addr,
   output logic [7:0] reg_wdata,
   input  logic       reg_ack,
   input  logic [7:0] reg_rdata,
   output logic       busy,
   output logic       done,
   output logic       err
);

   localparam int POLL_TRIES = (POLL_LIMIT_CYC / POLL_GAP_CYC < 1) ? 1
                               : POLL_LIMIT_CYC / POLL_GAP_CYC;
   localparam int TRY_W   = $clog2(POLL_TRIES + 1);
   localparam int TMR_MAX = (POLL_GAP_CYC > SETTLE_CYC) ? POLL_GAP_CYC : SETTLE_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam int CAL_W   = $clog2(COMP_LIMIT_CYC + 1);

   generate
      if (POLL_GAP_CYC < 1) begin : g_bad_gap
         $error("POLL_GAP_CYC must be at least 1");
      end
      if (POLL_LIMIT_CYC < POLL_GAP_CYC) begin : g_bad_limit
         $error("POLL_LIMIT_CYC must not be below POLL_GAP_CYC");
      end
      if (SETTLE_CYC < 1 || COMP_LIMIT_CYC < 1) begin : g_bad_wait
         $error("SETTLE_CYC and COMP_LIMIT_CYC must be at least 1");
      end
   endgenerate

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_XFER, S_GAP, S_SETTLE, S_DONE, S_ERR
   } state_e;

   state_e              state_q;
   logic [STEP_W-1:0]   idx_q;
   logic [1:0]          gen_q;
   logic                inv_q;
   logic [TRY_W-1:0]    tries_q;
   logic [CAL_W-1:0]    cal_cnt_q;
   step_t               step;
   logic                poll_ok;
   logic                poll_fail_ack;
   logic                tmr_load;
   logic [TMR_W-1:0]    tmr_val;
   logic                tmr_exp;
   logic                cal_expired;

   lane_seq_rom u_rom (
      .idx  (idx_q),
      .gen  (gen_q),
      .inv  (inv_q),
      .step (step)
   );

   always_comb begin
      if (step.op == OP_POLL_LO) poll_ok = ((reg_rdata & step.val) == 8'h00);
      else                       poll_ok = ((reg_rdata & step.val) == step.val);
   end

   assign poll_fail_ack = (state_q == S_XFER) && reg_ack && !reg_we && !poll_ok;
   assign tmr_load = ((state_q == S_FETCH) && (step.op == OP_SETTLE)) ||
                     (poll_fail_ack && (step.op != OP_POLL_CAL));
   assign tmr_val  = (step.op == OP_SETTLE) ? TMR_W'(SETTLE_CYC) : TMR_W'(POLL_GAP_CYC);
   assign cal_expired = (cal_cnt_q >= CAL_W'(COMP_LIMIT_CYC));

   lane_seq_timer #(.MAX_CNT(TMR_MAX), .CNT_W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   // compensation watch: cycles spent on the calibration poll step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                            cal_cnt_q <= '0;
      else if (step.op != OP_POLL_CAL || state_q == S_IDLE)  cal_cnt_q <= '0;
      else if (!cal_expired)                                 cal_cnt_q <= cal_cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         idx_q     <= '0;
         gen_q     <= 2'd1;
         inv_q     <= 1'b0;
         tries_q   <= '0;
         reg_req   <= 1'b0;
         reg_we    <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
      end else begin
         case (state_q)
            S_IDLE, S_DONE, S_ERR: begin
               if (start) begin
                  gen_q   <= (gen_sel == 2'd0) ? 2'd1 : gen_sel;
                  inv_q   <= tx_inv;
                  idx_q   <= '0;
                  tries_q <= '0;
                  state_q <= S_FETCH;
               end
            end
            S_FETCH: begin
               case (step.op)
                  OP_SKIP:   idx_q   <= idx_q + 1'b1;
                  OP_END:    state_q <= S_DONE;
                  OP_SETTLE: state_q <= S_SETTLE;
                  OP_WR: begin
                     reg_req   <= 1'b1;
                     reg_we    <= 1'b1;
                     reg_addr  <= step.addr;
                     reg_wdata <= step.val;
                     state_q   <= S_XFER;
                  end
                  default: begin
                     reg_req   <= 1'b1;
                     reg_we    <= 1'b0;
                     reg_addr  <= step.addr;
                     reg_wdata <= 8'h00;
                     state_q   <= S_XFER;
                  end
               endcase
            end
            S_XFER: begin
               if (reg_ack) begin
                  reg_req <= 1'b0;
                  if (reg_we || poll_ok) begin
                     idx_q   <= idx_q + 1'b1;
                     tries_q <= '0;
                     state_q <= S_FETCH;
                  end else if (step.op == OP_POLL_CAL) begin
                     state_q <= cal_expired ? S_ERR : S_FETCH;
                  end else if (tries_q == TRY_W'(POLL_TRIES - 1)) begin
                     state_q <= S_ERR;
                  end else begin
                     tries_q <= tries_q + 1'b1;
                     state_q <= S_GAP;
                  end
               end
            end
            S_GAP: begin
               if (tmr_exp) state_q <= S_FETCH;
            end
            S_SETTLE: begin
               if (tmr_exp) begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= S_FETCH;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy = (state_q == S_FETCH) || (state_q == S_XFER) ||
                 (state_q == S_GAP)   || (state_q == S_SETTLE);
   assign done = (state_q == S_DONE);
   assign err  = (state_q == S_ERR);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)); // R2
   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && reg_ack |=> !reg_req); // R2
   AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err)); // R11
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done && !busy); // R11
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      err && !start |=> err && !busy); // R11
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !reg_req); // R12
   AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_req) |-> $past(state_q) == S_FETCH); // R4

endmodule

// File: tb/lane_bringup_seq_bench.sv
`timescale 1ns/1ps
module lane_bringup_seq_bench;

   localparam int GAP    = 8;
   localparam int LIMIT  = 40;
   localparam int SETTLE = 20;
   localparam int COMPL  = 60;
   localparam int TRIES  = LIMIT / GAP;
   localparam int STUCK  = 1000;

   typedef struct {
      bit         we;
      logic [7:0] addr;
      logic [7:0] data;
      bit         rep;
      string      tag;
   } xact_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] gen_sel = 2'd1;
   logic       tx_inv = 1'b0;
   logic       reg_req, reg_we, reg_ack;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic       busy, done, err;

   always #4 clk = ~clk;

   lane_bringup_seq #(
      .POLL_GAP_CYC(GAP), .POLL_LIMIT_CYC(LIMIT),
      .SETTLE_CYC(SETTLE), .COMP_LIMIT_CYC(COMPL)
   ) u_lane_bringup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .gen_sel(gen_sel), .tx_inv(tx_inv),
      .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_ack(reg_ack), .reg_rdata(reg_rdata),
      .busy(busy), .done(done), .err(err)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    finished = 0;
   xact_t exp_q[$];

   // register model state
   logic [7:0] mem [256];
   int  k1, k2, k3, lat;
   int  st1_n, st2_n, cal_n;
   bit  ssc_phase;
   int  cyc = 0;
   int  last_ack_cyc;
   int  need_gap;
   string gap_tag;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, expv, cyc);
      end
   endtask

   function automatic logic [7:0] model_read(input logic [7:0] a);
      logic [7:0] r;
      if (a == 8'h01) begin
         if (!ssc_phase) begin r = (st1_n < k1) ? 8'h03 : 8'h00; st1_n++; end
         else            begin r = (st2_n < k2) ? 8'h00 : 8'h03; st2_n++; end
      end else if (a == 8'h40) begin
         r = (cal_n < k3) ? 8'h04 : 8'h0C; cal_n++;
      end else r = mem[a];
      return r;
   endfunction

   // responder: acks each request after lat cycles and checks it
   initial begin
      int  w;
      bit  seen;
      xact_t e;
      reg_ack = 1'b0; reg_rdata = 8'h00; w = 0; seen = 0; need_gap = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) check(!(done && err), "R11 done/err exclusive", {done, err}, 0);
         if (reg_ack) begin
            reg_ack = 1'b0;
         end else if (reg_req) begin
            if (!seen) begin
               seen = 1;
               if (need_gap > 0)
                  check(cyc - last_ack_cyc >= need_gap, gap_tag, cyc - last_ack_cyc, need_gap);
               need_gap = 0;
            end
            if (w < lat) w++;
            else begin
               w = 0; seen = 0;
               if (exp_q.size() == 0) begin
                  check(0, "R12 unexpected transfer", reg_addr, 0);
               end else begin
                  e = exp_q[0];
                  check(reg_we == e.we && reg_addr == e.addr && (!e.we || reg_wdata == e.data),
                        e.tag, {reg_we, reg_addr, reg_wdata}, {e.we, e.addr, e.data});
                  if (!e.rep) void'(exp_q.pop_front());
               end
               if (reg_we) begin
                  mem[reg_addr] = reg_wdata;
                  if (reg_addr == 8'h50) ssc_phase = 1;
                  if (reg_addr == 8'h00 && reg_wdata == 8'h10 && mem[8'h56] === 8'hxx) begin
                     need_gap = SETTLE; gap_tag = "R7 settle gap";
                  end
               end else begin
                  reg_rdata = model_read(reg_addr);
                  if (reg_addr == 8'h01 &&
                      ((!ssc_phase && reg_rdata[1:0] != 2'b00) || (ssc_phase && reg_rdata[1:0] != 2'b11))) begin
                     need_gap = GAP; gap_tag = ssc_phase ? "R9 poll gap" : "R4 poll gap";
                  end
               end
               reg_ack = 1'b1;
               last_ack_cyc = cyc;
            end
         end
      end
   end

   task automatic pw(input logic [7:0] a, input logic [7:0] d, input string tag);
      xact_t e;
      e.we = 1; e.addr = a; e.data = d; e.rep = 0; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic pr(input logic [7:0] a, input bit rep, input string tag);
      xact_t e;
      e.we = 0; e.addr = a; e.data = 8'h00; e.rep = rep; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // stop: 0 full run, 1 first poll stuck, 2 calibration stuck, 3 second poll stuck
   task automatic build_exp(input int g_in, input bit inv, input int stop);
      int g;
      logic [1:0] m;
      g = (g_in == 0) ? 1 : g_in;
      m = 2'(g - 1);
      exp_q.delete();
      pw(8'h00, 8'h96, "R3 full reset");
      if (inv) pw(8'h02, 8'h20, "R3 polarity");
      pw(8'h10, 8'h01, "R3 speed select source");
      pw(8'h72, 8'h40, "R3 rx clock phase");
      pw(8'h12, {3'b000, m, 1'b0, m}, "R3 speed code");
      for (int i = 0; i < ((stop == 1) ? TRIES : k1 + 1); i++) pr(8'h01, 0, "R4 status clear poll");
      if (stop == 1) return;
      pw(8'h41, (g == 1) ? 8'h1E : 8'h0F, "R5 comp ratio");
      if (g != 3) begin
         pw(8'h42, 8'h33, "R5 comp ref");
         pw(8'h51, 8'h02, "R5 pll bypass");
         pw(8'h47, 8'h2A, "R5 comp idll");
      end
      pw(8'h40, 8'h13, "R5 comp start");
      if (stop == 2) begin pr(8'h40, 1, "R5 comp poll"); return; end
      for (int i = 0; i < k3 + 1; i++) pr(8'h40, 0, "R5 comp poll");
      if (g == 3) begin
         pw(8'h20, 8'h12, "R6 g3 bank"); pw(8'h21, 8'h64, "R6 g3 swing");
         pw(8'h22, 8'h02, "R6 g3 slew"); pw(8'h23, 8'h00, "R6 g3 offset");
         pw(8'h25, 8'h31, "R6 g3 rx");
      end else if (g == 2) begin
         pw(8'h20, 8'h01, "R6 g2 bank"); pw(8'h21, 8'h04, "R6 g2 swing");
         pw(8'h22, 8'h02, "R6 g2 slew"); pw(8'h25, 8'h11, "R6 g2 rx");
      end else begin
         pw(8'h20, 8'h10, "R6 g1 bank"); pw(8'h21, 8'h03, "R6 g1 swing");
         pw(8'h22, 8'h04, "R6 g1 slew");
      end
      pw(8'h00, 8'h10, "R7 rx reset only");
      pw(8'h56, 8'h03, "R8 ssc"); pw(8'h57, 8'h63, "R8 ssc");
      pw(8'h58, 8'h00, "R8 ssc"); pw(8'h59, 8'hF1, "R8 ssc");
      pw(8'h50, (g == 1) ? 8'h8D : 8'hCD, "R8 pll ctrl");
      for (int i = 0; i < ((stop == 3) ? TRIES : k2 + 1); i++) pr(8'h01, 0, "R9 status set poll");
      if (stop == 3) return;
      pw(8'h10, 8'h00, "R10 close"); pw(8'h72, 8'h00, "R10 close");
      pw(8'h00, 8'h10, "R10 close"); pw(8'h02, inv ? 8'h28 : 8'h08, "R10 lock enable");
      pw(8'h86, 8'h61, "R10 bit lock"); pw(8'h00, 8'h00, "R10 release");
   endtask

   task automatic run_case(input int g, input bit inv, input int a1, input int a2, input int a3,
                           input int stop, input int l, input bit mid_start);
      int t;
      k1 = a1; k2 = a2; k3 = a3; lat = l;
      st1_n = 0; st2_n = 0; cal_n = 0; ssc_phase = 0; need_gap = 0;
      for (int i = 0; i < 256; i++) mem[i] = 8'hxx;
      build_exp(g, inv, stop);
      @(negedge clk);
      gen_sel = 2'(g); tx_inv = inv; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!done && !err && t < 20000) begin
         @(negedge clk); t++;
         if (mid_start && t == 40) begin
            start = 1'b1; gen_sel = 2'd3; tx_inv = ~inv;
            @(negedge clk); start = 1'b0; t++;
         end
      end
      if (stop == 0) check(done && !err, "R10 done raised", {done, err}, 2'b10);
      else           check(err && !done, "R12 err raised", {done, err}, 2'b01);
      repeat (30) @(negedge clk);
      if (stop == 0) check(done && !busy, "R11 done held", {done, busy}, 2'b10);
      else           check(err && !busy && !reg_req, "R12 err held, quiet", {err, busy, reg_req}, 3'b100);
      while (exp_q.size() > 0 && exp_q[0].rep) void'(exp_q.pop_front());
      check(exp_q.size() == 0, "R2 all transfers seen", exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check(!reg_req && !busy && !done && !err, "R1 reset state", {reg_req, busy, done, err}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!reg_req && !busy && !done && !err, "R1 idle after reset", {reg_req, busy, done, err}, 0);
      run_case(1, 0, 2, 1, 2, 0, 1, 0);
      run_case(2, 1, 0, 3, 0, 0, 2, 1);
      run_case(3, 0, 1, 0, 3, 0, 0, 0);
      run_case(3, 1, 0, 0, 0, 0, 1, 0);
      run_case(0, 0, 1, 1, 1, 0, 1, 0);
      run_case(2, 0, STUCK, 0, 0, 1, 1, 0);
      run_case(1, 0, 0, 0, STUCK, 2, 1, 0);
      run_case(3, 1, 0, STUCK, 0, 3, 0, 0);
      run_case(1, 1, TRIES - 1, TRIES - 1, 0, 0, 1, 0);
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule